// File: doc/BRIEF.md
# Single-Pointer Coherence Directory Controller

This block keeps the coherence directory for one memory module. Each tracked block has one entry made of a state, a single pointer/counter field and a trap bit. Processors send it one of four request kinds for a block address: get exclusive, get shared, put (give a copy back) and prefetch exclusive. The controller settles every case that needs at most one reply in hardware. It sends data to the requester, stores returned data, or forwards data to a processor that prefetched the block while another processor held it exclusive.

The pointer/counter field has two uses. In the owned states it names the single writer. In the shared state it counts readers. Any request that would need more than one message, or that the protocol does not allow, gets a trap response and sets the entry's trap bit. While the trap bit is set, every later request to that block is answered busy. A software handler reads and rewrites entries through a side port, and it clears the trap bit through that port when it has finished.

The block accepts one request per cycle. Its response is registered and appears on the cycle after the request.

Top module: `onePtrDirectory`

## Requirements
- R1: After reset every entry reads state Idle (code 0), pointer/counter 0 and trap bit 0, and the response kind is None (code 0).
- R2: A request is answered on the cycle after it is accepted. A cycle with no request yields response None on the next cycle. The response destination is the requester for every kind except Forward (code 2). Request kind codes are: GetX 0, GetS 1, Put 2, PrefX 3.
- R3: GetX on an Idle entry responds Data (code 1). The entry moves to Owned (code 2) with the pointer set to the requester.
- R4: GetS on Idle responds Data, and the entry moves to Shared (code 1) with counter 1. GetS on Shared responds Data and increments the counter. If the counter is already at its all-ones maximum, GetS on Shared traps instead.
- R5: Put on Owned responds Store (code 3), and the entry moves to Idle with the pointer cleared. Put on Shared responds None and decrements the counter. The entry becomes Idle when a counter of 1 is decremented.
- R6: PrefX on Idle responds Data, and the entry moves to Owned with the pointer set to the requester. PrefX on Owned responds None, and the entry moves to OwnedPend (code 3) with the pointer set to the prefetcher. PrefX on Shared or OwnedPend responds None and changes nothing.
- R7: Put on OwnedPend responds Forward with the destination taken from the pointer. The entry moves to Owned and keeps the pointer.
- R8: The following requests respond Trap (code 4), leave state and pointer unchanged, and set the trap bit: GetX on Shared, Owned or OwnedPend; GetS on Owned or OwnedPend; Put on Idle.
- R9: While an entry's trap bit is 1, every request to it responds Busy (code 5) and leaves the entry unchanged.
- R10: The side port reads the entry at its address combinationally. A side-port write replaces state, pointer/counter and trap bit at the next clock edge.
- R11: If a side-port write and a request target the same block in the same cycle, the request responds Busy and the entry takes the side-port values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqKind | input | 2 | Request kind: 0 GetX, 1 GetS, 2 Put, 3 PrefX |
| reqProc | input | PROC_W | Requesting processor |
| reqAddr | input | ADDR_W | Block index |
| rspKind | output | 3 | 0 None, 1 Data, 2 Forward, 3 Store, 4 Trap, 5 Busy |
| rspDest | output | PROC_W | Processor that receives the response |
| swAddr | input | ADDR_W | Side-port block index |
| swWrite | input | 1 | Side-port write strobe |
| swState | input | 2 | State to write |
| swPtr | input | PROC_W+1 | Pointer/counter to write |
| swTrap | input | 1 | Trap bit to write |
| swRdState | output | 2 | State at swAddr |
| swRdPtr | output | PROC_W+1 | Pointer/counter at swAddr |
| swRdTrap | output | 1 | Trap bit at swAddr |

## Verification
The main sweep preloads an entry through the side port with every state, several pointer/counter values and both trap-bit values. It then sends each request kind from each processor, which covers every pairing of state and request. This separates the hardware-handled transitions from the traps and the busy answers. The pointer values include 0, 1 and the counter maximum, so the sweep also tells the last-reader release apart from an ordinary decrement and a counter saturation trap. Directed sequences build a reader count up to saturation, take it back down to Idle, run a prefetch hand-off from one owner to another, and issue a side-port write in the same cycle as a request.

// File: rtl/dirsw_pkg.sv
package dirsw_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SHARED = 2'd1, ST_OWNED = 2'd2, ST_PEND = 2'd3} dirState_e;
  typedef enum logic [1:0] {RQ_GETX = 2'd0, RQ_GETS = 2'd1, RQ_PUT = 2'd2, RQ_PREFX = 2'd3} reqKind_e;
  typedef enum logic [2:0] {RS_NONE = 3'd0, RS_DATA = 3'd1, RS_FWD = 3'd2, RS_STORE = 3'd3,
                            RS_TRAP = 3'd4, RS_BUSY = 3'd5} rspKind_e;
  typedef enum logic [2:0] {PT_HOLD, PT_LOAD_REQ, PT_ONE, PT_INC, PT_DEC, PT_CLEAR} ptrOp_e;

  typedef struct packed {
    logic      wrEn;
    dirState_e nextState;
    ptrOp_e    ptrOp;
    logic      setTrap;
  } dirStrobe_t;
endpackage

// File: rtl/dirEntryStore.sv
module dirEntryStore
  import dirsw_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int PROC_W     = 4,
  parameter int CNT_W      = PROC_W + 1,
  parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [PROC_W-1:0] reqProc,
  input  dirStrobe_t        strobe,
  input  logic [ADDR_W-1:0] swAddr,
  input  logic              swWrite,
  input  logic [1:0]        swState,
  input  logic [CNT_W-1:0]  swPtr,
  input  logic              swTrap,
  output dirState_e         curState,
  output logic [CNT_W-1:0]  curPtr,
  output logic              curTrap,
  output logic [1:0]        swRdState,
  output logic [CNT_W-1:0]  swRdPtr,
  output logic              swRdTrap
);
  dirState_e        stArr   [NUM_BLOCKS];
  logic [CNT_W-1:0] ptrArr  [NUM_BLOCKS];
  logic             trapArr [NUM_BLOCKS];
  logic [CNT_W-1:0] ptrNext;

  assign curState  = stArr[reqAddr];
  assign curPtr    = ptrArr[reqAddr];
  assign curTrap   = trapArr[reqAddr];
  assign swRdState = stArr[swAddr];
  assign swRdPtr   = ptrArr[swAddr];
  assign swRdTrap  = trapArr[swAddr];

  // pointer/counter arithmetic selected by the control strobe
  always_comb begin
    case (strobe.ptrOp)
      PT_LOAD_REQ: ptrNext = CNT_W'(reqProc);
      PT_ONE:      ptrNext = CNT_W'(1);
      PT_INC:      ptrNext = curPtr + CNT_W'(1);
      PT_DEC:      ptrNext = curPtr - CNT_W'(1);
      PT_CLEAR:    ptrNext = '0;
      default:     ptrNext = curPtr;
    endcase
  end

  // the side-port write takes priority over the protocol update
  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (!rstN) begin
        stArr[b]   <= ST_IDLE;
        ptrArr[b]  <= '0;
        trapArr[b] <= 1'b0;
      end else if (swWrite && swAddr == ADDR_W'(b)) begin
        stArr[b]   <= dirState_e'(swState);
        ptrArr[b]  <= swPtr;
        trapArr[b] <= swTrap;
      end else if (strobe.wrEn && reqAddr == ADDR_W'(b)) begin
        stArr[b]  <= strobe.nextState;
        ptrArr[b] <= ptrNext;
        if (strobe.setTrap) trapArr[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dirProtoCtrl.sv
module dirProtoCtrl
  import dirsw_pkg::*;
#(
  parameter int PROC_W = 4,
  parameter int CNT_W  = PROC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [PROC_W-1:0] reqProc,
  input  logic              swCollide,
  input  dirState_e         curState,
  input  logic [CNT_W-1:0]  curPtr,
  input  logic              curTrap,
  output dirStrobe_t        strobe,
  output logic [2:0]        rspKind,
  output logic [PROC_W-1:0] rspDest
);
  rspKind_e kindNext;
  logic     ctrMax, ctrOne, doTrap;

  assign ctrMax = (curPtr == {CNT_W{1'b1}});
  assign ctrOne = (curPtr == CNT_W'(1));

  always_comb begin
    kindNext         = RS_NONE;
    doTrap           = 1'b0;
    strobe.wrEn      = 1'b0;
    strobe.nextState = curState;
    strobe.ptrOp     = PT_HOLD;
    strobe.setTrap   = 1'b0;
    if (reqValid) begin
      if (curTrap || swCollide) begin
        kindNext = RS_BUSY;
      end else begin
        case (reqKind_e'(reqKind))
          RQ_GETX: begin
            if (curState == ST_IDLE) begin
              kindNext = RS_DATA; strobe.wrEn = 1'b1;
              strobe.nextState = ST_OWNED; strobe.ptrOp = PT_LOAD_REQ;
            end else doTrap = 1'b1;
          end
          RQ_GETS: begin
            if (curState == ST_IDLE) begin
              kindNext = RS_DATA; strobe.wrEn = 1'b1;
              strobe.nextState = ST_SHARED; strobe.ptrOp = PT_ONE;
            end else if (curState == ST_SHARED && !ctrMax) begin
              kindNext = RS_DATA; strobe.wrEn = 1'b1; strobe.ptrOp = PT_INC;
            end else doTrap = 1'b1;
          end
          RQ_PUT: begin
            case (curState)
              ST_OWNED: begin
                kindNext = RS_STORE; strobe.wrEn = 1'b1;
                strobe.nextState = ST_IDLE; strobe.ptrOp = PT_CLEAR;
              end
              ST_SHARED: begin
                strobe.wrEn = 1'b1; strobe.ptrOp = PT_DEC;
                if (ctrOne) strobe.nextState = ST_IDLE;
              end
              ST_PEND: begin
                kindNext = RS_FWD; strobe.wrEn = 1'b1; strobe.nextState = ST_OWNED;
              end
              default: doTrap = 1'b1;
            endcase
          end
          default: begin
            if (curState == ST_IDLE) begin
              kindNext = RS_DATA; strobe.wrEn = 1'b1;
              strobe.nextState = ST_OWNED; strobe.ptrOp = PT_LOAD_REQ;
            end else if (curState == ST_OWNED) begin
              strobe.wrEn = 1'b1; strobe.nextState = ST_PEND; strobe.ptrOp = PT_LOAD_REQ;
            end
          end
        endcase
        if (doTrap) begin
          kindNext = RS_TRAP; strobe.wrEn = 1'b1; strobe.setTrap = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspKind <= RS_NONE;
      rspDest <= '0;
    end else begin
      rspKind <= kindNext;
      rspDest <= (kindNext == RS_FWD) ? curPtr[PROC_W-1:0] : reqProc;
    end
  end
endmodule

// File: rtl/onePtrDirectory.sv
module onePtrDirectory
  import dirsw_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int PROC_W     = 4,
  parameter int CNT_W      = PROC_W + 1,
  parameter int ADDR_W     = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [PROC_W-1:0] reqProc,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [2:0]        rspKind,
  output logic [PROC_W-1:0] rspDest,
  input  logic [ADDR_W-1:0] swAddr,
  input  logic              swWrite,
  input  logic [1:0]        swState,
  input  logic [CNT_W-1:0]  swPtr,
  input  logic              swTrap,
  output logic [1:0]        swRdState,
  output logic [CNT_W-1:0]  swRdPtr,
  output logic              swRdTrap
);
  dirStrobe_t       strobe;
  dirState_e        curState;
  logic [CNT_W-1:0] curPtr;
  logic             curTrap;
  logic             swCollide;

  assign swCollide = swWrite && (swAddr == reqAddr);

  dirProtoCtrl #(.PROC_W(PROC_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqProc(reqProc),
    .swCollide(swCollide), .curState(curState), .curPtr(curPtr), .curTrap(curTrap),
    .strobe(strobe), .rspKind(rspKind), .rspDest(rspDest)
  );

  dirEntryStore #(.NUM_BLOCKS(NUM_BLOCKS), .PROC_W(PROC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_store (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqProc(reqProc), .strobe(strobe),
    .swAddr(swAddr), .swWrite(swWrite), .swState(swState), .swPtr(swPtr), .swTrap(swTrap),
    .curState(curState), .curPtr(curPtr), .curTrap(curTrap),
    .swRdState(swRdState), .swRdPtr(swRdPtr), .swRdTrap(swRdTrap)
  );
endmodule

// File: rtl/dirCheck.sv
module dirCheck #(
  parameter int PROC_W = 4,
  parameter int CNT_W  = PROC_W + 1,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqKind,
  input logic [PROC_W-1:0] reqProc,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [2:0]        rspKind,
  input logic [PROC_W-1:0] rspDest,
  input logic [ADDR_W-1:0] swAddr,
  input logic              swWrite,
  input logic [1:0]        swState,
  input logic [CNT_W-1:0]  swPtr,
  input logic              swTrap,
  input logic [1:0]        swRdState,
  input logic [CNT_W-1:0]  swRdPtr,
  input logic              swRdTrap
);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> rspKind == 3'd0);
  p_dest_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rspKind != 3'd0 && rspKind != 3'd2) |-> rspDest == $past(reqProc));
  p_data_not_put_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspKind == 3'd1 |-> $past(reqKind) != 2'd2);
  p_store_from_put_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspKind == 3'd3 |-> $past(reqKind) == 2'd2);
  p_fwd_from_put_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspKind == 3'd2 |-> $past(reqKind) == 2'd2);
  p_side_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    swWrite |=> (!$stable(swAddr) ||
      (swRdState == $past(swState) && swRdPtr == $past(swPtr) && swRdTrap == $past(swTrap))));
  p_collide_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && swWrite && swAddr == reqAddr) |=> rspKind == 3'd5);
endmodule

bind onePtrDirectory dirCheck #(.PROC_W(PROC_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dirCheck (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqProc(reqProc),
  .reqAddr(reqAddr), .rspKind(rspKind), .rspDest(rspDest), .swAddr(swAddr), .swWrite(swWrite),
  .swState(swState), .swPtr(swPtr), .swTrap(swTrap), .swRdState(swRdState),
  .swRdPtr(swRdPtr), .swRdTrap(swRdTrap)
);

// File: tb/test_onePtrDirectory.sv
module test_onePtrDirectory;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 4;
  localparam int PW  = 2;
  localparam int CW  = PW + 1;
  localparam int AW  = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = '0;
  logic [PW-1:0] reqProc = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [2:0] rspKind;
  logic [PW-1:0] rspDest;
  logic [AW-1:0] swAddr = '0;
  logic swWrite = 1'b0;
  logic [1:0] swState = '0;
  logic [CW-1:0] swPtr = '0;
  logic swTrap = 1'b0;
  logic [1:0] swRdState;
  logic [CW-1:0] swRdPtr;
  logic swRdTrap;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onePtrDirectory #(.NUM_BLOCKS(NB), .PROC_W(PW)) i_onePtrDirectory (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqProc(reqProc),
    .reqAddr(reqAddr), .rspKind(rspKind), .rspDest(rspDest), .swAddr(swAddr),
    .swWrite(swWrite), .swState(swState), .swPtr(swPtr), .swTrap(swTrap),
    .swRdState(swRdState), .swRdPtr(swRdPtr), .swRdTrap(swRdTrap)
  );

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic swSet(input int a, input int st, input int p, input int t);
    swWrite = 1'b1; swAddr = AW'(a); swState = 2'(st); swPtr = CW'(p); swTrap = t[0];
    @(negedge clk);
    swWrite = 1'b0;
  endtask

  // issue at a negedge, return at the next negedge with the response visible
  task automatic issue(input int a, input int k, input int p);
    reqValid = 1'b1; reqAddr = AW'(a); reqKind = 2'(k); reqProc = PW'(p);
    @(negedge clk);
    reqValid = 1'b0;
    swAddr = AW'(a);
    #1;
  endtask

  task automatic expectAll(input string tag, input int rk, input int rd,
                           input int st, input int p, input int t);
    check({tag, " kind"}, int'(rspKind), rk);
    if (rk != 0) check({tag, " dest"}, int'(rspDest), rd);
    check({tag, " state"}, int'(swRdState), st);
    check({tag, " ptr"}, int'(swRdPtr), p);
    check({tag, " trap"}, int'(swRdTrap), t);
  endtask

  // expected outcome derived from the requirement list
  task automatic model(input int st, input int p, input int k, input int pr, input int t,
                       output int rk, output int rd, output int nst, output int np,
                       output int nt, output string tag);
    rk = 0; rd = pr; nst = st; np = p; nt = t; tag = "R2";
    if (t != 0) begin
      rk = 5; tag = "R9";
    end else begin
      case (k)
        0: if (st == 0) begin rk = 1; nst = 2; np = pr; tag = "R3"; end
           else begin rk = 4; nt = 1; tag = "R8"; end
        1: if (st == 0) begin rk = 1; nst = 1; np = 1; tag = "R4"; end
           else if (st == 1 && p != CMAX) begin rk = 1; np = p + 1; tag = "R4"; end
           else if (st == 1) begin rk = 4; nt = 1; tag = "R4"; end
           else begin rk = 4; nt = 1; tag = "R8"; end
        2: if (st == 2) begin rk = 3; nst = 0; np = 0; tag = "R5"; end
           else if (st == 1) begin np = (p + CMAX) % (CMAX + 1); nst = (p == 1) ? 0 : 1; tag = "R5"; end
           else if (st == 3) begin rk = 2; rd = p % (1 << PW); nst = 2; tag = "R7"; end
           else begin rk = 4; nt = 1; tag = "R8"; end
        default: begin
           tag = "R6";
           if (st == 0) begin rk = 1; nst = 2; np = pr; end
           else if (st == 2) begin nst = 3; np = pr; end
        end
      endcase
    end
  endtask

  initial begin
    int ptrSet[4] = '{0, 1, 3, CMAX};
    int rk, rd, nst, np, nt;
    string tag;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 rsp", int'(rspKind), 0);
    for (int a = 0; a < NB; a++) begin
      swAddr = AW'(a); #1;
      check("R1 state", int'(swRdState), 0);
      check("R1 ptr", int'(swRdPtr), 0);
      check("R1 trap", int'(swRdTrap), 0);
    end
    @(negedge clk);
    check("R2 idle none", int'(rspKind), 0);

    // full sweep of state x pointer x kind x processor x trap bit
    for (int st = 0; st < 4; st++)
      for (int pi = 0; pi < 4; pi++)
        for (int k = 0; k < 4; k++)
          for (int pr = 0; pr < (1 << PW); pr++)
            for (int t = 0; t < 2; t++) begin
              int a = (st + k + pr) % NB;
              swSet(a, st, ptrSet[pi], t);
              issue(a, k, pr);
              model(st, ptrSet[pi], k, pr, t, rk, rd, nst, np, nt, tag);
              expectAll(tag, rk, rd, nst, np, nt);
              @(negedge clk);
              check("R2 quiet after", int'(rspKind), 0);
            end

    // R4: readers count up to saturation, then trap
    swSet(1, 0, 0, 0);
    for (int n = 1; n <= CMAX; n++) begin
      issue(1, 1, n % 4);
      expectAll("R4 build", 1, n % 4, 1, n, 0);
    end
    issue(1, 1, 2);
    expectAll("R4 saturate", 4, 2, 1, CMAX, 1);
    // R5: readers drain back to idle
    swSet(1, 1, CMAX, 0);
    for (int n = CMAX - 1; n >= 0; n--) begin
      issue(1, 2, 0);
      expectAll("R5 drain", 0, 0, (n == 0) ? 0 : 1, n, 0);
    end

    // R6/R7: owner 1, prefetcher 3, put forwards to 3
    swSet(2, 0, 0, 0);
    issue(2, 0, 1); expectAll("R3 own", 1, 1, 2, 1, 0);
    issue(2, 3, 3); expectAll("R6 pend", 0, 0, 3, 3, 0);
    issue(2, 1, 0); expectAll("R8 pend gets", 4, 0, 3, 3, 1);
    swSet(2, 3, 3, 0);
    issue(2, 2, 1); expectAll("R7 fwd", 2, 3, 2, 3, 0);
    issue(2, 2, 3); expectAll("R5 store", 3, 3, 0, 0, 0);

    // R9: busy then software clears the bit and the request succeeds
    swSet(0, 0, 0, 1);
    issue(0, 0, 2); expectAll("R9 busy", 5, 2, 0, 0, 1);
    swSet(0, 0, 0, 0);
    issue(0, 0, 2); expectAll("R9 after clear", 1, 2, 2, 2, 0);

    // R11: side-port write and request in the same cycle
    swSet(3, 0, 0, 0);
    reqValid = 1'b1; reqAddr = 2'd3; reqKind = 2'd0; reqProc = 2'd1;
    swWrite = 1'b1; swAddr = 2'd3; swState = 2'd1; swPtr = 3'd2; swTrap = 1'b0;
    @(negedge clk);
    reqValid = 1'b0; swWrite = 1'b0; #1;
    expectAll("R11 collide", 5, 1, 1, 2, 0);
    // R10: write to another block leaves neighbour intact and reads back
    swSet(0, 2, 5, 1);
    swAddr = 2'd0; #1;
    check("R10 state", int'(swRdState), 2);
    check("R10 ptr", int'(swRdPtr), 5);
    check("R10 trap", int'(swRdTrap), 1);
    swAddr = 2'd3; #1;
    check("R10 neighbour", int'(swRdPtr), 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule